// File: doc/BRIEF.md
# Sign-Extending Word Load Unit

This block executes one family of word loads for a 64-bit big-endian core. It takes a 32-bit instruction word together with the two register-file read values the instruction names. It forms a byte address from a base register plus either a scaled immediate or a second register. It then reads one 32-bit word over a valid/ready memory port and writes the word, sign-extended to 64 bits, back to the destination register. The update variant also writes the computed address back into its base register.

Three encodings are accepted. Any other word raises a one-cycle illegal pulse. The two malformed update encodings raise a one-cycle invalid-form pulse. Neither case issues a memory request or writes a register. The unit handles one load at a time and reports busy from acceptance until its writeback cycle ends.

Top module: `swl_load_unit`

## Requirements
- R1: Instruction bit 0 is the MSB (`insn[31]`), so the primary opcode is `insn[31:26]`. The unit accepts three encodings:
  - displacement form: opcode 58 with the 2-bit subfield `insn[1:0]` equal to 2;
  - indexed form: opcode 31 with `insn[10:1]` equal to 341 and `insn[0]` equal to 0;
  - indexed-update form: opcode 31 with `insn[10:1]` equal to 373 and `insn[0]` equal to 0.
- R2: Any other word presented while idle, including subfield values 0 and 1 under opcode 58, asserts `illegal` for exactly one cycle, the cycle after acceptance. It issues no memory request and makes no register write.
- R3: In the displacement form the offset is `insn[15:2]` as a signed 14-bit value, with two zero bits appended and then sign-extended to 64 bits.
- R4: The destination index is `insn[25:21]` and the base index is `insn[20:16]`. The index register is `insn[15:11]` in the indexed forms. In the displacement and indexed forms, a base index of 0 selects the constant zero instead of `ra_data`.
- R5: The effective address is base plus offset (or plus `rb_data`), modulo 2^64. The full 64 bits go to `mem_addr`, and unaligned addresses are issued unchanged.
- R6: `mem_req_valid` rises the cycle after acceptance. It stays high with `mem_addr` stable until `mem_req_ready` is seen high at a clock edge.
- R7: The returned word has its lowest-address byte in bits 31:24. The destination receives it as a signed 32-bit value sign-extended to 64 bits.
- R8: The write ports pulse for exactly one cycle, the cycle after the edge where `mem_rsp_valid` was high. `wr_t_en` rises with the destination index.
- R9: For the indexed-update form, `wr_a_en` is asserted in the same cycle as `wr_t_en`, writing the effective address to the base index. The other forms never assert `wr_a_en`.
- R10: An indexed-update word whose base index is 0 or equals its destination index asserts `invalid_form` for one cycle. It issues no request and makes no register write.
- R11: `busy` is high from the cycle after acceptance through the writeback cycle. Instruction words presented while busy are ignored.
- R12: After reset, `busy`, `mem_req_valid`, `wr_t_en`, `wr_a_en`, `illegal` and `invalid_form` are all low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word presented |
| insn | input | 32 | Instruction word |
| rf_ra_idx | output | 5 | Base register index for the read port |
| rf_rb_idx | output | 5 | Index register index for the read port |
| ra_data | input | 64 | Base register value, valid with `insn_valid` |
| rb_data | input | 64 | Index register value, valid with `insn_valid` |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word, big-endian byte order |
| wr_t_en | output | 1 | Destination write enable |
| wr_t_addr | output | 5 | Destination index |
| wr_t_data | output | 64 | Sign-extended load result |
| wr_a_en | output | 1 | Base write enable (update form) |
| wr_a_addr | output | 5 | Base index |
| wr_a_data | output | 64 | Effective address |
| busy | output | 1 | Load in flight |
| illegal | output | 1 | Unrecognised encoding pulse |
| invalid_form | output | 1 | Malformed update encoding pulse |

## Verification
On every cycle the assertions check these relations:
- the request stays held with a stable address while it is stalled;
- a write always follows an accepted response;
- the upper half of the result copies bit 31;
- the base writeback never occurs without the destination write or with a forbidden index;
- flag pulses occur only while idle.

Only the bench scenarios can show the numeric correctness of the address, because the assertions do not compute the expected sum. This covers scaled negative and maximal displacements, the zero-base substitution, wraparound, the exact decoding of neighbouring encodings, and the discarding of instructions offered while busy.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int XLEN = 64;
  localparam int WLEN = 32;
  localparam int RIDX = 5;
  localparam int DSW  = 14;

  typedef enum logic [1:0] {
    FORM_NONE,
    FORM_DISP,
    FORM_IDX,
    FORM_IDXU
  } form_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_WB
  } state_e;
endpackage

// File: rtl/swl_decode.sv
module swl_decode
  import swl_pkg::*;
#(
  parameter int IW  = 32,
  parameter int RW  = RIDX,
  parameter int DW  = DSW
) (
  input  logic [IW-1:0] insn,
  output form_e         form,
  output logic          dec_illegal,
  output logic          dec_inval,
  output logic [RW-1:0] rt,
  output logic [RW-1:0] ra,
  output logic [RW-1:0] rb,
  output logic [DW-1:0] ds
);
  localparam logic [5:0] OP_DISP = 6'd58;
  localparam logic [5:0] OP_IDX  = 6'd31;
  localparam logic [1:0] SUB_WA  = 2'd2;
  localparam logic [9:0] XO_IDX  = 10'd341;
  localparam logic [9:0] XO_IDXU = 10'd373;

  logic [5:0] opcd;
  logic [1:0] sub2;
  logic [9:0] xo10;
  logic       rc;

  assign opcd = insn[IW-1 -: 6];
  assign rt   = insn[IW-7 -: RW];
  assign ra   = insn[IW-12 -: RW];
  assign rb   = insn[IW-17 -: RW];
  assign ds   = insn[DW+1:2];
  assign sub2 = insn[1:0];
  assign xo10 = insn[10:1];
  assign rc   = insn[0];

  always_comb begin
    form = FORM_NONE;
    if (opcd == OP_DISP && sub2 == SUB_WA) begin
      form = FORM_DISP;
    end else if (opcd == OP_IDX && !rc && xo10 == XO_IDX) begin
      form = FORM_IDX;
    end else if (opcd == OP_IDX && !rc && xo10 == XO_IDXU) begin
      form = FORM_IDXU;
    end
  end

  assign dec_illegal = (form == FORM_NONE);
  assign dec_inval   = (form == FORM_IDXU) && ((ra == '0) || (ra == rt));
endmodule

// File: rtl/swl_agen.sv
module swl_agen #(
  parameter int XW = 64,
  parameter int DW = 14
) (
  input  logic [XW-1:0] base_val,
  input  logic [XW-1:0] index_val,
  input  logic [DW-1:0] ds,
  input  logic          use_disp,
  input  logic          base_zero,
  output logic [XW-1:0] ea
);
  localparam int PAD = XW - DW - 2;

  logic [XW-1:0] base;
  logic [XW-1:0] offset;

  always_comb begin
    base   = base_zero ? '0 : base_val;
    offset = use_disp ? {{PAD{ds[DW-1]}}, ds, 2'b00} : index_val;
    ea     = base + offset;
  end
endmodule

// File: rtl/swl_load_unit.sv
module swl_load_unit
  import swl_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int WW = WLEN,
  parameter int RW = RIDX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_valid,
  input  logic [31:0]   insn,
  output logic [RW-1:0] rf_ra_idx,
  output logic [RW-1:0] rf_rb_idx,
  input  logic [XW-1:0] ra_data,
  input  logic [XW-1:0] rb_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [XW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [WW-1:0] mem_rsp_data,
  output logic          wr_t_en,
  output logic [RW-1:0] wr_t_addr,
  output logic [XW-1:0] wr_t_data,
  output logic          wr_a_en,
  output logic [RW-1:0] wr_a_addr,
  output logic [XW-1:0] wr_a_data,
  output logic          busy,
  output logic          illegal,
  output logic          invalid_form
);
  localparam int EXT = XW - WW;

  form_e         dec_form;
  logic          dec_illegal;
  logic          dec_inval;
  logic [RW-1:0] dec_rt;
  logic [RW-1:0] dec_ra;
  logic [RW-1:0] dec_rb;
  logic [DSW-1:0] dec_ds;
  logic [XW-1:0] ea;

  state_e        state_q, state_d;
  logic [XW-1:0] addr_q, addr_d;
  logic [XW-1:0] data_q, data_d;
  logic [RW-1:0] rt_q, rt_d;
  logic [RW-1:0] ra_q, ra_d;
  logic          upd_q, upd_d;
  logic          ill_q, ill_d;
  logic          inv_q, inv_d;
  logic          accept;

  swl_decode #(.IW(32), .RW(RW), .DW(DSW)) u_decode (
    .insn        (insn),
    .form        (dec_form),
    .dec_illegal (dec_illegal),
    .dec_inval   (dec_inval),
    .rt          (dec_rt),
    .ra          (dec_ra),
    .rb          (dec_rb),
    .ds          (dec_ds)
  );

  swl_agen #(.XW(XW), .DW(DSW)) u_agen (
    .base_val  (ra_data),
    .index_val (rb_data),
    .ds        (dec_ds),
    .use_disp  (dec_form == FORM_DISP),
    .base_zero ((dec_ra == '0) && (dec_form != FORM_IDXU)),
    .ea        (ea)
  );

  assign rf_ra_idx = dec_ra;
  assign rf_rb_idx = dec_rb;
  assign accept    = insn_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    data_d  = data_q;
    rt_d    = rt_q;
    ra_d    = ra_q;
    upd_d   = upd_q;
    ill_d   = accept && dec_illegal;
    inv_d   = accept && !dec_illegal && dec_inval;
    case (state_q)
      ST_IDLE: begin
        if (accept && !dec_illegal && !dec_inval) begin
          state_d = ST_REQ;
          addr_d  = ea;
          rt_d    = dec_rt;
          ra_d    = dec_ra;
          upd_d   = (dec_form == FORM_IDXU);
        end
      end
      ST_REQ: begin
        if (mem_req_ready) state_d = ST_RSP;
      end
      ST_RSP: begin
        if (mem_rsp_valid) begin
          state_d = ST_WB;
          data_d  = {{EXT{mem_rsp_data[WW-1]}}, mem_rsp_data};
        end
      end
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      rt_q    <= '0;
      ra_q    <= '0;
      upd_q   <= 1'b0;
      ill_q   <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      rt_q    <= rt_d;
      ra_q    <= ra_d;
      upd_q   <= upd_d;
      ill_q   <= ill_d;
      inv_q   <= inv_d;
    end
  end

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_addr      = addr_q;
  assign wr_t_en       = (state_q == ST_WB);
  assign wr_t_addr     = rt_q;
  assign wr_t_data     = data_q;
  assign wr_a_en       = (state_q == ST_WB) && upd_q;
  assign wr_a_addr     = ra_q;
  assign wr_a_data     = addr_q;
  assign busy          = (state_q != ST_IDLE);
  assign illegal       = ill_q;
  assign invalid_form  = inv_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R6

  AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t_en |-> $past(mem_rsp_valid)); // R8

  AST_SEXT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t_en |-> wr_t_data[XW-1:WW] == {EXT{wr_t_data[WW-1]}}); // R7

  AST_UPD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_en |-> wr_t_en && (wr_a_addr != '0) && (wr_a_addr != wr_t_addr)); // R10

  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal || invalid_form) |-> !busy && !mem_req_valid && !wr_t_en); // R2

  AST_SINGLE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t_en |=> !wr_t_en); // R8
endmodule

// File: tb/test_swl_load_unit.sv
`timescale 1ns/1ps
module test_swl_load_unit;
  logic        clk;
  logic        rst_n;
  logic        insn_valid;
  logic [31:0] insn;
  logic [4:0]  rf_ra_idx, rf_rb_idx;
  logic [63:0] ra_data, rb_data;
  logic        mem_req_valid, mem_req_ready;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        wr_t_en, wr_a_en;
  logic [4:0]  wr_t_addr, wr_a_addr;
  logic [63:0] wr_t_data, wr_a_data;
  logic        busy, illegal, invalid_form;

  int checks = 0;
  int fails  = 0;

  swl_load_unit i_swl_load_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .rf_ra_idx(rf_ra_idx), .rf_rb_idx(rf_rb_idx),
    .ra_data(ra_data), .rb_data(rb_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .wr_t_en(wr_t_en), .wr_t_addr(wr_t_addr), .wr_t_data(wr_t_data),
    .wr_a_en(wr_a_en), .wr_a_addr(wr_a_addr), .wr_a_data(wr_a_data),
    .busy(busy), .illegal(illegal), .invalid_form(invalid_form)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] iw;
    logic [63:0] a;
    logic [63:0] b;
    logic [31:0] word;
    logic [63:0] addr;
    logic [63:0] res;
    logic        upd;
    logic [4:0]  t;
    logic [4:0]  ai;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    // R3 R7: positive scaled offset, negative word
    '{32'hE8640016, 64'h1000, 64'h0, 32'h80000001, 64'h1014,
      64'hFFFFFFFF80000001, 1'b0, 5'd3, 5'd4},
    // R3 R4 R5: offset -4, zero base, wraps below zero
    '{32'hE840FFFE, 64'h1234, 64'h0, 32'h7FFFFFFF, 64'hFFFFFFFFFFFFFFFC,
      64'h000000007FFFFFFF, 1'b0, 5'd2, 5'd0},
    // R5: indexed, unaligned address
    '{32'h7C221AAA, 64'h100, 64'h3, 32'h12345678, 64'h103,
      64'h0000000012345678, 1'b0, 5'd1, 5'd2},
    // R4: indexed with base index 0 ignores ra_data
    '{32'h7C804AAA, 64'hDEAD, 64'h2000, 32'hFFFFFFFF, 64'h2000,
      64'hFFFFFFFFFFFFFFFF, 1'b0, 5'd4, 5'd0},
    // R9 R5: update form, sum wraps past 2^64
    '{32'h7CA63AEA, 64'hFFFFFFFFFFFFFFF0, 64'h20, 32'h00008000, 64'h10,
      64'h0000000000008000, 1'b1, 5'd5, 5'd6},
    // R3: largest positive displacement
    '{32'hEBE17FFE, 64'h10000, 64'h0, 32'h80000000, 64'h17FFC,
      64'hFFFFFFFF80000000, 1'b0, 5'd31, 5'd1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    @(negedge clk);
    insn_valid = 1'b1; insn = v.iw; ra_data = v.a; rb_data = v.b;
    @(negedge clk);
    insn_valid = 1'b0;
    chk("R6 req raised", {63'b0, mem_req_valid}, 64'd1);
    chk("R11 busy after accept", {63'b0, busy}, 64'd1);
    chk("R5 address", mem_addr, v.addr);
    if (poke) begin
      insn_valid = 1'b1; insn = 32'h00000000;
    end
    @(negedge clk);
    if (poke) begin
      chk("R11 word ignored while busy", {63'b0, illegal}, 64'd0);
      insn_valid = 1'b0;
    end
    chk("R6 req held while stalled", {63'b0, mem_req_valid}, 64'd1);
    chk("R6 address stable", mem_addr, v.addr);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R6 req dropped after ready", {63'b0, mem_req_valid}, 64'd0);
    chk("R8 no early write", {63'b0, wr_t_en}, 64'd0);
    mem_rsp_valid = 1'b1; mem_rsp_data = v.word;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R8 dest write", {63'b0, wr_t_en}, 64'd1);
    chk("R8 dest index", {59'b0, wr_t_addr}, {59'b0, v.t});
    chk("R7 result", wr_t_data, v.res);
    chk("R9 base write enable", {63'b0, wr_a_en}, {63'b0, v.upd});
    if (v.upd) begin
      chk("R9 base index", {59'b0, wr_a_addr}, {59'b0, v.ai});
      chk("R9 base data", wr_a_data, v.addr);
    end
    @(negedge clk);
    chk("R8 single write cycle", {63'b0, wr_t_en}, 64'd0);
    chk("R11 idle after writeback", {63'b0, busy}, 64'd0);
  endtask

  task automatic flag_case(input logic [31:0] iw, input bit expect_ill, input string tag);
    @(negedge clk);
    insn_valid = 1'b1; insn = iw; ra_data = 64'h40; rb_data = 64'h8;
    @(negedge clk);
    insn_valid = 1'b0;
    chk({tag, " illegal"}, {63'b0, illegal}, {63'b0, expect_ill});
    chk({tag, " invalid_form"}, {63'b0, invalid_form}, {63'b0, !expect_ill});
    chk({tag, " no request"}, {63'b0, mem_req_valid}, 64'd0);
    chk({tag, " not busy"}, {63'b0, busy}, 64'd0);
    @(negedge clk);
    chk({tag, " pulse one cycle"}, {63'b0, illegal | invalid_form}, 64'd0);
    chk({tag, " no write"}, {62'b0, wr_t_en, wr_a_en}, 64'd0);
    chk({tag, " still no request"}, {63'b0, mem_req_valid}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; ra_data = '0; rb_data = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset outputs",
        {58'b0, busy, mem_req_valid, wr_t_en, wr_a_en, illegal, invalid_form}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle after release", {63'b0, busy}, 64'd0);

    // R1: table walk of accepted encodings
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i == 2);

    // R2: neighbouring encodings rejected
    flag_case(32'hE8640014, 1'b1, "R2 subfield 0");
    flag_case(32'hE8640015, 1'b1, "R2 subfield 1");
    flag_case(32'h7C22182A, 1'b1, "R2 other xo");
    flag_case(32'h7C221AAB, 1'b1, "R1 record bit set");
    // R10: malformed update forms
    flag_case(32'h7CA03AEA, 1'b0, "R10 base zero");
    flag_case(32'h7CA53AEA, 1'b0, "R10 base equals dest");

    // R1: unit still functional after flags
    run_vec(VECS[0], 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule